// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects two parallel buses, A and B, through a pair of storage registers, one per direction. Each bus appears as an input, an output and an output-enable, so the tristate drivers at the pads stay outside the block. Each register has its own capture strobe. The block samples the strobes in the system clock domain, and a rising edge on a strobe loads that register from its own bus. Capture does not depend on which bus, if either, is being driven.

An active-low enable and a direction input choose the driven bus. When the enable is high, both buses are isolated and the registers go on capturing. With direction low, bus A is driven from the B-to-A path. With direction high, bus B is driven from the A-to-B path. A select per path chooses live data from the source bus (select low) or the stored register of that path (select high). All outputs are registered, so every output value is settled one clock after the inputs that produced it, and switching a select can never show a mix of live and stored bits.

Top module: `bus_xcvr_reg`

## Requirements
- R1: A cycle in which `cap_a` is 1 and was 0 in the previous cycle loads `a_in` into the A register at that clock edge, whatever the values of `en_n` and `dir`.
- R2: A cycle in which `cap_b` is 1 and was 0 in the previous cycle loads `b_in` into the B register at that clock edge, whatever the values of `en_n` and `dir`.
- R3: When both strobes rise in the same cycle, both registers load at the same edge.
- R4: With `en_n` = 1, both `a_oe` and `b_oe` are 0 after the next edge, and captures still take place.
- R5: With `en_n` = 0 and `dir` = 0, `a_oe` = 1 and `b_oe` = 0 after the next edge. `a_out` carries the B register when `sel_ba` = 1 and live `b_in` when `sel_ba` = 0.
- R6: With `en_n` = 0 and `dir` = 1, `b_oe` = 1 and `a_oe` = 0 after the next edge. `b_out` carries the A register when `sel_ab` = 1 and live `a_in` when `sel_ab` = 0.
- R7: `a_oe` and `b_oe` are never 1 together.
- R8: Synchronous active-high `rst` clears both registers and both data outputs to zero and ignores strobe edges. The output enables still follow `en_n` and `dir`.
- R9: Outputs change only at clock edges, one cycle after their inputs. A stored value read in the same cycle as a capture shows the value held before that capture.
- R10: A strobe held high captures only once. The register keeps its value until the strobe falls and rises again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en_n | input | 1 | Output enable, active low |
| dir | input | 1 | 0 drives bus A, 1 drives bus B |
| sel_ab | input | 1 | A-to-B path: 0 live, 1 stored |
| sel_ba | input | 1 | B-to-A path: 0 live, 1 stored |
| cap_a | input | 1 | Capture strobe for the A register |
| cap_b | input | 1 | Capture strobe for the B register |
| a_in | input | W | Bus A input |
| b_in | input | W | Bus B input |
| a_out | output | W | Bus A output data |
| a_oe | output | 1 | Bus A output enable |
| b_out | output | W | Bus B output data |
| b_oe | output | 1 | Bus B output enable |

## Verification
A capture and a stored-data read of the same register can occur in the same cycle. The bench provokes this by raising a strobe while that path is driven with its select high. It expects the old register contents at that edge and the new capture one cycle later. Both strobes also rise together while the outputs are isolated, and both captured values are then read back through the stored paths.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic [1:0] {
    DRV_NONE = 2'd0,
    DRV_A    = 2'd1,
    DRV_B    = 2'd2
  } drive_t;

  function automatic drive_t pick_drive(input logic en_n, input logic dir);
    if (en_n)     return DRV_NONE;
    else if (dir) return DRV_B;
    else          return DRV_A;
  endfunction
endpackage

// File: rtl/edge_rise.sv
module edge_rise (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= lvl;
  end

  assign rise = lvl & ~prev;

  // R10
  no_double_rise_chk: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/cap_reg.sv
module cap_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end

  // R1
  cap_load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (q == $past(d)));

  // R10
  cap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q));
endmodule

// File: rtl/path_sel.sv
module path_sel #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sel,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  output logic [W-1:0] out
);
  always_ff @(posedge clk) begin
    if (rst) out <= '0;
    else     out <= sel ? stored : live;
  end

  // R9
  no_mix_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (out == $past(live) || out == $past(stored)));
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_n,
  input  logic         dir,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic         cap_a,
  input  logic         cap_b,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  output logic [W-1:0] b_out,
  output logic         b_oe
);
  localparam int NSIDE = 2;

  logic [NSIDE-1:0] cap_lvl;
  logic [NSIDE-1:0] cap_rise;
  logic [NSIDE-1:0] sel_src;
  logic [W-1:0]     bus_in   [NSIDE];
  logic [W-1:0]     stored   [NSIDE];
  logic [W-1:0]     path_out [NSIDE];
  drive_t           drv;

  assign cap_lvl   = {cap_b, cap_a};
  assign sel_src   = {sel_ba, sel_ab};
  assign bus_in[0] = a_in;
  assign bus_in[1] = b_in;

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    edge_rise u_edge (
      .clk  (clk),
      .rst  (rst),
      .lvl  (cap_lvl[s]),
      .rise (cap_rise[s])
    );

    cap_reg #(.W(W)) u_reg (
      .clk  (clk),
      .rst  (rst),
      .load (cap_rise[s]),
      .d    (bus_in[s]),
      .q    (stored[s])
    );

    path_sel #(.W(W)) u_path (
      .clk    (clk),
      .rst    (rst),
      .sel    (sel_src[s]),
      .live   (bus_in[s]),
      .stored (stored[s]),
      .out    (path_out[s])
    );
  end

  assign b_out = path_out[0];
  assign a_out = path_out[1];

  assign drv = pick_drive(en_n, dir);

  always_ff @(posedge clk) begin
    a_oe <= (drv == DRV_A);
    b_oe <= (drv == DRV_B);
  end

  // R7
  oe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(a_oe && b_oe));

  // R4
  iso_chk: assert property (@(posedge clk) disable iff (rst)
    en_n |=> (!a_oe && !b_oe));

  // R5
  drive_a_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_n && !dir) |=> a_oe);

  // R6
  drive_b_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_n && dir) |=> b_oe);

  // R3
  dual_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_rise == 2'b11) |=> (stored[0] == $past(a_in) && stored[1] == $past(b_in)));
endmodule

// File: tb/sim_bus_xcvr_reg.sv
module sim_bus_xcvr_reg;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic         en_n, dir, sel_ab, sel_ba, cap_a, cap_b;
  logic [W-1:0] a_in, b_in;
  logic [W-1:0] a_out, b_out;
  logic         a_oe, b_oe;

  int n_chk  = 0;
  int n_fail = 0;

  logic [W-1:0] m_a, m_b;
  logic         p_a, p_b;

  always #2.5 clk = ~clk;

  bus_xcvr_reg #(.W(W)) u0 (
    .clk(clk), .rst(rst), .en_n(en_n), .dir(dir), .sel_ab(sel_ab),
    .sel_ba(sel_ba), .cap_a(cap_a), .cap_b(cap_b), .a_in(a_in),
    .b_in(b_in), .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
  );

  // bits: en_n dir sel_ab sel_ba cap_a cap_b | a_in | b_in
  localparam int NV = 13;
  localparam logic [21:0] VEC [NV] = '{
    {6'b100010, 8'h11, 8'h22},  // R1 capture A while isolated
    {6'b100001, 8'h33, 8'h44},  // R2 capture B while isolated
    {6'b000100, 8'h55, 8'h66},  // stored B onto A
    {6'b000000, 8'h55, 8'h77},  // live B onto A
    {6'b011000, 8'h00, 8'h00},  // stored A onto B
    {6'b010000, 8'h88, 8'h00},  // live A onto B
    {6'b100011, 8'h9A, 8'hBC},  // R3 both capture
    {6'b011110, 8'hDE, 8'h01},  // R10 strobe held high
    {6'b001100, 8'h02, 8'h03},
    {6'b011010, 8'h5A, 8'h04},  // capture and stored read together
    {6'b011010, 8'h5A, 8'h05},
    {6'b000101, 8'h06, 8'h3C},
    {6'b000100, 8'h07, 8'h08}
  };

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [21:0] v, input string tag);
    logic [W-1:0] ea, eb;
    logic         eao, ebo;
    @(negedge clk);
    {en_n, dir, sel_ab, sel_ba, cap_a, cap_b, a_in, b_in} = v;
    eb  = sel_ab ? m_a : a_in;
    ea  = sel_ba ? m_b : b_in;
    eao = !en_n && !dir;
    ebo = !en_n && dir;
    if (cap_a && !p_a) m_a = a_in;
    if (cap_b && !p_b) m_b = b_in;
    p_a = cap_a;
    p_b = cap_b;
    @(negedge clk);
    chk({tag, " R5 a_out"}, a_out, ea);
    chk({tag, " R6 b_out"}, b_out, eb);
    chk({tag, " R4/R7 a_oe"}, {7'd0, a_oe}, {7'd0, eao});
    chk({tag, " R4/R7 b_oe"}, {7'd0, b_oe}, {7'd0, ebo});
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1;
    {en_n, dir, sel_ab, sel_ba, cap_a, cap_b} = 6'b000000;
    a_in = 8'hAA; b_in = 8'hBB;
    m_a = '0; m_b = '0; p_a = 1'b0; p_b = 1'b0;
    @(negedge clk);
    cap_a = 1'b1; cap_b = 1'b1;  // edges during reset are ignored
    @(negedge clk);
    cap_a = 1'b0; cap_b = 1'b0;
    @(negedge clk);
    // R8 reset state: data zero, enables follow en_n/dir
    chk("R8 a_out", a_out, 8'h00);
    chk("R8 b_out", b_out, 8'h00);
    chk("R8 a_oe", {7'd0, a_oe}, 8'h01);
    chk("R8 b_oe", {7'd0, b_oe}, 8'h00);
    rst = 1'b0;
    step({6'b001100, 8'h12, 8'h34}, "R8 stored A/B zero after reset");
    step({6'b011100, 8'h12, 8'h34}, "R8 stored A zero after reset");

    for (int i = 0; i < NV; i++) step(VEC[i], "table");

    // R1 capture while B is driven
    step({6'b010010, 8'hC1, 8'h00}, "R1 cap");
    step({6'b011000, 8'h00, 8'h00}, "R1 read");
    chk("R1 direct", b_out, 8'hC1);
    // R2 capture while A is driven
    step({6'b000001, 8'h00, 8'hD2}, "R2 cap");
    step({6'b000100, 8'h00, 8'h00}, "R2 read");
    chk("R2 direct", a_out, 8'hD2);
    // R3 both strobes rise together while isolated
    step({6'b100011, 8'hE3, 8'hF4}, "R3 cap");
    step({6'b011100, 8'h00, 8'h00}, "R3 readA");
    chk("R3 A", b_out, 8'hE3);
    step({6'b001100, 8'h00, 8'h00}, "R3 readB");
    chk("R3 B", a_out, 8'hF4);
    // R10 held strobe, new data does not load
    step({6'b100010, 8'h61, 8'h00}, "R10 rise");
    step({6'b100010, 8'h62, 8'h00}, "R10 held");
    step({6'b011000, 8'h63, 8'h00}, "R10 read");
    chk("R10 held", b_out, 8'h61);

    // R9 output stable between edges
    step({6'b010000, 8'h70, 8'h00}, "R9 live");
    #1 a_in = 8'h71;
    #0.5 chk("R9 mid-cycle", b_out, 8'h70);
    @(negedge clk);
    chk("R9 next edge", b_out, 8'h71);
    m_a = m_a;  // live path only, model unchanged

    // all enable/direction/select combinations, R4 R5 R6 R7
    for (int c = 0; c < 16; c++)
      step({c[3:0], 2'b00, 8'h10 + 8'(c), 8'h80 + 8'(c)}, "combo");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule